// File: doc/BRIEF.md
# Direct/Indirect Route Path Selector

This block chooses the way out for a packet entering a two-level network built from groups of switches. Each group reaches every other group over one or more global links. A packet can go straight to its destination group, which costs at most three hops (local, global, local). It can also detour through one intermediate group, which costs at most five hops (local, global, local, global, local). The selector looks at the source group, the destination group and a 2-bit mode. It returns the route class, the group that the first global hop targets, and the first-hop port number taken from small programmable route tables.

When several choices exist, the block spreads traffic over them. In multi-direct mode it rotates among the parallel global links towards the destination. In the indirect modes it picks an intermediate group. Candidates are worked out per packet: any group below the configured group count that is neither the source nor the destination. The pick is made round-robin, or it starts from a pseudo-random draw. Packets that stay inside their own group use a separate intra-group table.

The decision is combinational from request to result. State (the rotation pointers, the round-robin pointer and the random generator) moves only on a completed handshake.

Top module: `route_path_selector`

## Requirements
- R1: After reset the round-robin pointer is 0, the random generator holds 16'hACE1, every per-destination rotation pointer is 0, and every table entry (base port and link count) is 0; no result is offered while no request is present.
- R2: The handshake passes straight through. `outValid` equals `reqValid`, `reqReady` equals `outReady`, and a request is consumed in a cycle where both are high.
- R3: When source and destination groups are equal, in every mode, the class is intra (code 0), the via group is the destination, and the port is the intra-table base for that group.
- R4: In mode 0 (single direct) the class is direct (code 1), the via group is the destination, and the port is the inter-table base for the destination.
- R5: In mode 1 (multi direct) the port is the inter-table base plus an offset. The offset steps 0, 1, ... up to the entry's link count (stored as count minus one), then wraps to 0. Each destination group keeps its own pointer, which moves once per consumed packet. A pointer above the current link count reads as 0.
- R6: In mode 2 (round-robin indirect) the class is indirect (code 2). The via group is the first eligible group found by scanning upward from the pointer, wrapping modulo 16. The port is the inter-table base of the via group.
- R7: The round-robin pointer becomes via+1 (modulo 16) only when a mode-2 indirect packet is consumed. A stalled request leaves it unchanged.
- R8: In mode 3 (random indirect) the scan starts at the generator's low 4 bits. On each consumed mode-3 indirect packet the generator shifts left, and the new bit 0 is bit15^bit13^bit12^bit10.
- R9: With a group count of 2 or less, modes 2 and 3 route exactly as mode 0, and neither the round-robin pointer nor the generator moves.
- R10: A write with `tblWe` high updates the intra table (`tblIntra`=1) or the inter table (`tblIntra`=0) at `tblIdx`. The new entry is used from the next cycle on.
- R11: An intermediate group is never the source group, never the destination group, and never at or above the group count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| groupCount | input | 5 | Number of populated groups (2..16) |
| tblWe | input | 1 | Route-table write strobe |
| tblIntra | input | 1 | 1 selects the intra-group table, 0 the inter-group table |
| tblIdx | input | 4 | Group index of the entry written |
| tblBase | input | 6 | Base port of the entry |
| tblLinks | input | 2 | Parallel link count minus one (inter table) |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Request accepted by downstream |
| srcGroup | input | 4 | Source group |
| dstGroup | input | 4 | Destination group |
| routeMode | input | 2 | 0 single direct, 1 multi direct, 2 indirect round-robin, 3 indirect random |
| outValid | output | 1 | Result present |
| outReady | input | 1 | Downstream accepts the result |
| outClass | output | 2 | 0 intra, 1 direct, 2 indirect |
| outVia | output | 4 | Group targeted by the first global hop |
| outPort | output | 6 | First-hop port number |

## Verification
The bench checks that the round-robin scan skips the source and the destination when they sit right at the pointer, and that it wraps past the unpopulated upper groups back to 0. A design that fails to exclude an endpoint would return the source or the destination as the intermediate. A design that ignores the group count would pick an empty group. Stalled requests are held for several cycles to show the pointer stays put; a design stepping on valid alone would skip a candidate. Other cases target per-destination rotation interleaved across two destinations, the fall-back to direct with two groups (a wrong design would move the pointer or the generator and shift later picks), and a table rewrite used on the very next packet.

// File: rtl/route_sel_pkg.sv
`timescale 1ns/1ps
package route_sel_pkg;
  typedef enum logic [1:0] {
    RC_INTRA    = 2'd0,
    RC_DIRECT   = 2'd1,
    RC_INDIRECT = 2'd2
  } routeClassE;

  typedef enum logic [1:0] {
    MD_SINGLE  = 2'd0,
    MD_MULTI   = 2'd1,
    MD_IND_RR  = 2'd2,
    MD_IND_RND = 2'd3
  } routeModeE;

  typedef struct packed {
    logic selIntra;
    logic selIndirect;
    logic selRandom;
    logic selRotate;
    logic stepRr;
    logic stepRnd;
    logic stepRot;
  } selStrobeS;
endpackage

// File: rtl/route_sel_ctrl.sv
`timescale 1ns/1ps
module route_sel_ctrl
  import route_sel_pkg::*;
#(
  parameter int GROUP_W = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  input  logic               outReady,
  input  logic [GROUP_W-1:0] srcGroup,
  input  logic [GROUP_W-1:0] dstGroup,
  input  logic [1:0]         routeMode,
  input  logic [GROUP_W:0]   groupCount,
  output logic               reqReady,
  output logic               outValid,
  output selStrobeS          strobe
);
  logic fire;
  logic sameGrp;
  logic fewGroups;

  assign fire      = reqValid && outReady;
  assign reqReady  = outReady;
  assign outValid  = reqValid;
  assign sameGrp   = (srcGroup == dstGroup);
  assign fewGroups = (groupCount <= (GROUP_W+1)'(2));

  always_comb begin
    strobe             = '0;
    strobe.selIntra    = sameGrp;
    strobe.selIndirect = !sameGrp && routeMode[1] && !fewGroups;
    strobe.selRandom   = strobe.selIndirect && (routeMode == MD_IND_RND);
    strobe.selRotate   = !sameGrp && (routeMode == MD_MULTI);
    strobe.stepRr      = fire && strobe.selIndirect && !strobe.selRandom;
    strobe.stepRnd     = fire && strobe.selRandom;
    strobe.stepRot     = fire && strobe.selRotate;
  end

  AST_NO_STEP_STALLED: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !outReady) |-> !(strobe.stepRr || strobe.stepRnd || strobe.stepRot)); // R7
  AST_ONE_STEP: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.stepRr, strobe.stepRnd, strobe.stepRot})); // R2
endmodule

// File: rtl/route_sel_dp.sv
`timescale 1ns/1ps
module route_sel_dp
  import route_sel_pkg::*;
#(
  parameter int          GROUP_W   = 4,
  parameter int          PORT_W    = 6,
  parameter int          LINK_W    = 2,
  parameter logic [15:0] LFSR_SEED = 16'hACE1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [GROUP_W-1:0] srcGroup,
  input  logic [GROUP_W-1:0] dstGroup,
  input  logic [GROUP_W:0]   groupCount,
  input  selStrobeS          strobe,
  input  logic               tblWe,
  input  logic               tblIntra,
  input  logic [GROUP_W-1:0] tblIdx,
  input  logic [PORT_W-1:0]  tblBase,
  input  logic [LINK_W-1:0]  tblLinks,
  output routeClassE         routeClass,
  output logic [GROUP_W-1:0] viaGroup,
  output logic [PORT_W-1:0]  portNum
);
  localparam int NG = 1 << GROUP_W;

  logic [PORT_W-1:0]  interBase  [NG];
  logic [PORT_W-1:0]  intraBase  [NG];
  logic [LINK_W-1:0]  interLinks [NG];
  logic [LINK_W-1:0]  rotPtr     [NG];
  logic [GROUP_W-1:0] rrPtr;
  logic [15:0]        lfsr;
  logic               lfsrFb;

  logic [NG-1:0]      elig;
  logic [GROUP_W-1:0] scanStart;
  logic [GROUP_W-1:0] scanIdx;
  logic [GROUP_W-1:0] pick;
  logic               found;
  logic [LINK_W-1:0]  dstLinks;
  logic [LINK_W-1:0]  rotOff;

  // candidate set: populated groups other than both endpoints
  for (genvar g = 0; g < NG; g++) begin : gElig
    localparam logic [GROUP_W:0] G_IDX = (GROUP_W+1)'(g);
    assign elig[g] = (G_IDX < groupCount) &&
                     (G_IDX[GROUP_W-1:0] != srcGroup) &&
                     (G_IDX[GROUP_W-1:0] != dstGroup);
  end

  assign scanStart = strobe.selRandom ? lfsr[GROUP_W-1:0] : rrPtr;

  always_comb begin
    found   = 1'b0;
    pick    = scanStart;
    scanIdx = scanStart;
    for (int k = 0; k < NG; k++) begin
      scanIdx = scanStart + GROUP_W'(k);
      if (!found && elig[scanIdx]) begin
        found = 1'b1;
        pick  = scanIdx;
      end
    end
  end

  assign dstLinks = interLinks[dstGroup];
  assign rotOff   = (rotPtr[dstGroup] > dstLinks) ? '0 : rotPtr[dstGroup];
  assign lfsrFb   = lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10];

  always_comb begin
    if (strobe.selIntra) begin
      routeClass = RC_INTRA;
      viaGroup   = dstGroup;
      portNum    = intraBase[dstGroup];
    end else if (strobe.selIndirect) begin
      routeClass = RC_INDIRECT;
      viaGroup   = pick;
      portNum    = interBase[pick];
    end else begin
      routeClass = RC_DIRECT;
      viaGroup   = dstGroup;
      portNum    = interBase[dstGroup] +
                   (strobe.selRotate ? PORT_W'(rotOff) : '0);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rrPtr <= '0;
      lfsr  <= LFSR_SEED;
      for (int i = 0; i < NG; i++) begin
        interBase[i]  <= '0;
        intraBase[i]  <= '0;
        interLinks[i] <= '0;
        rotPtr[i]     <= '0;
      end
    end else begin
      if (strobe.stepRr)  rrPtr <= pick + GROUP_W'(1);
      if (strobe.stepRnd) lfsr  <= {lfsr[14:0], lfsrFb};
      if (strobe.stepRot)
        rotPtr[dstGroup] <= (rotOff == dstLinks) ? '0 : rotOff + LINK_W'(1);
      if (tblWe) begin
        if (tblIntra) begin
          intraBase[tblIdx] <= tblBase;
        end else begin
          interBase[tblIdx]  <= tblBase;
          interLinks[tblIdx] <= tblLinks;
        end
      end
    end
  end

  AST_MID_EXCLUDED: assert property (@(posedge clk) disable iff (!rstN)
    strobe.selIndirect |-> (pick != srcGroup) && (pick != dstGroup)); // R11
  AST_MID_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    strobe.selIndirect |-> ({1'b0, pick} < groupCount)); // R11
  AST_RR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.stepRr |=> $stable(rrPtr)); // R7
  AST_LFSR_LIVE: assert property (@(posedge clk) disable iff (!rstN)
    lfsr != 16'h0000); // R8
endmodule

// File: rtl/route_path_selector.sv
`timescale 1ns/1ps
module route_path_selector
  import route_sel_pkg::*;
#(
  parameter int GROUP_W = 4,
  parameter int PORT_W  = 6,
  parameter int LINK_W  = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [GROUP_W:0]   groupCount,
  input  logic               tblWe,
  input  logic               tblIntra,
  input  logic [GROUP_W-1:0] tblIdx,
  input  logic [PORT_W-1:0]  tblBase,
  input  logic [LINK_W-1:0]  tblLinks,
  input  logic               reqValid,
  output logic               reqReady,
  input  logic [GROUP_W-1:0] srcGroup,
  input  logic [GROUP_W-1:0] dstGroup,
  input  logic [1:0]         routeMode,
  output logic               outValid,
  input  logic               outReady,
  output logic [1:0]         outClass,
  output logic [GROUP_W-1:0] outVia,
  output logic [PORT_W-1:0]  outPort
);
  selStrobeS  strobe;
  routeClassE routeClass;

  route_sel_ctrl #(.GROUP_W(GROUP_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .outReady(outReady),
    .srcGroup(srcGroup), .dstGroup(dstGroup), .routeMode(routeMode),
    .groupCount(groupCount), .reqReady(reqReady), .outValid(outValid),
    .strobe(strobe)
  );

  route_sel_dp #(.GROUP_W(GROUP_W), .PORT_W(PORT_W), .LINK_W(LINK_W)) i_dp (
    .clk(clk), .rstN(rstN), .srcGroup(srcGroup), .dstGroup(dstGroup),
    .groupCount(groupCount), .strobe(strobe), .tblWe(tblWe),
    .tblIntra(tblIntra), .tblIdx(tblIdx), .tblBase(tblBase),
    .tblLinks(tblLinks), .routeClass(routeClass), .viaGroup(outVia),
    .portNum(outPort)
  );

  assign outClass = routeClass;

  AST_INTRA_CLASS: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && srcGroup == dstGroup) |-> (outClass == RC_INTRA)); // R3
  AST_FALLBACK_DIRECT: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && routeMode[1] && groupCount <= (GROUP_W+1)'(2) && srcGroup != dstGroup)
      |-> (outClass == RC_DIRECT && outVia == dstGroup)); // R9
endmodule

// File: tb/test_route_path_selector.sv
`timescale 1ns/1ps
module test_route_path_selector;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [4:0] groupCount = 5'd6;
  logic       tblWe = 1'b0;
  logic       tblIntra = 1'b0;
  logic [3:0] tblIdx = '0;
  logic [5:0] tblBase = '0;
  logic [1:0] tblLinks = '0;
  logic       reqValid = 1'b0;
  logic       reqReady;
  logic [3:0] srcGroup = '0;
  logic [3:0] dstGroup = '0;
  logic [1:0] routeMode = '0;
  logic       outValid;
  logic       outReady = 1'b0;
  logic [1:0] outClass;
  logic [3:0] outVia;
  logic [5:0] outPort;

  int checks = 0;
  int errors = 0;

  typedef struct packed { logic [1:0] cls; logic [3:0] via; logic [5:0] port; } expS;
  expS   expQ[$];
  string tagQ[$];

  // reference model state
  int          mIb[16];
  int          mIl[16];
  int          mTb[16];
  int          mRot[16];
  int          mRr;
  logic [15:0] mLfsr;
  int          mCount;

  always #5 clk = ~clk;

  route_path_selector i_route_path_selector (
    .clk(clk), .rstN(rstN), .groupCount(groupCount), .tblWe(tblWe),
    .tblIntra(tblIntra), .tblIdx(tblIdx), .tblBase(tblBase),
    .tblLinks(tblLinks), .reqValid(reqValid), .reqReady(reqReady),
    .srcGroup(srcGroup), .dstGroup(dstGroup), .routeMode(routeMode),
    .outValid(outValid), .outReady(outReady), .outClass(outClass),
    .outVia(outVia), .outPort(outPort)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic predict(input int s, input int d, input int md, output expS e);
    if (s == d) begin
      e.cls = 2'd0; e.via = 4'(d); e.port = 6'(mTb[d]);
    end else if (md >= 2 && mCount > 2) begin
      int st;
      int idx;
      bit hit;
      st  = (md == 3) ? int'(mLfsr[3:0]) : mRr;
      hit = 0;
      idx = st;
      for (int k = 0; k < 16; k++) begin
        int c;
        c = (st + k) % 16;
        if (!hit && c < mCount && c != s && c != d) begin
          hit = 1; idx = c;
        end
      end
      e.cls = 2'd2; e.via = 4'(idx); e.port = 6'(mIb[idx]);
      if (md == 2) mRr = (idx + 1) % 16;
      else mLfsr = {mLfsr[14:0], mLfsr[15] ^ mLfsr[13] ^ mLfsr[12] ^ mLfsr[10]};
    end else begin
      int off;
      off = 0;
      if (md == 1) begin
        off = (mRot[d] > mIl[d]) ? 0 : mRot[d];
        mRot[d] = (off == mIl[d]) ? 0 : off + 1;
      end
      e.cls = 2'd1; e.via = 4'(d); e.port = 6'((mIb[d] + off) % 64);
    end
  endtask

  task automatic send(input int s, input int d, input int md, input int stall,
                      input string tag);
    expS e;
    predict(s, d, md, e);
    expQ.push_back(e);
    tagQ.push_back(tag);
    @(posedge clk); #1;
    srcGroup = 4'(s); dstGroup = 4'(d); routeMode = 2'(md);
    reqValid = 1'b1;
    outReady = (stall == 0);
    repeat (stall) begin @(posedge clk); #1; end
    outReady = 1'b1;
    @(posedge clk); #1;
    reqValid = 1'b0;
  endtask

  task automatic wrTbl(input bit intra, input int idx, input int base, input int links);
    @(posedge clk); #1;
    tblWe = 1'b1; tblIntra = intra; tblIdx = 4'(idx);
    tblBase = 6'(base); tblLinks = 2'(links);
    if (intra) mTb[idx] = base;
    else begin mIb[idx] = base; mIl[idx] = links; end
    @(posedge clk); #1;
    tblWe = 1'b0;
  endtask

  task automatic setCount(input int n);
    @(posedge clk); #1;
    groupCount = 5'(n);
    mCount = n;
  endtask

  // monitor: compare results against the scoreboard as they are consumed
  always @(negedge clk) begin
    if (rstN && reqValid) begin
      chk(outValid === 1'b1, "R2", "outValid", int'(outValid), 1);
      if (outReady) begin
        chk(reqReady === 1'b1, "R2", "reqReady", int'(reqReady), 1);
        if (expQ.size() == 0) begin
          chk(1'b0, "R2", "unexpected result", 1, 0);
        end else begin
          expS   e;
          string t;
          e = expQ.pop_front();
          t = tagQ.pop_front();
          chk(outClass === e.cls, t, "class", int'(outClass), int'(e.cls));
          chk(outVia === e.via, t, "via", int'(outVia), int'(e.via));
          chk(outPort === e.port, t, "port", int'(outPort), int'(e.port));
        end
      end else begin
        chk(reqReady === 1'b0, "R2", "stalled reqReady", int'(reqReady), 0);
      end
    end
  end

  initial begin
    #1_000_000;
    checks++;
    errors++;
    $display("FAIL watchdog expired: actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) begin
      mIb[i] = 0; mIl[i] = 0; mTb[i] = 0; mRot[i] = 0;
    end
    mRr = 0; mLfsr = 16'hACE1; mCount = 6;
    repeat (4) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    chk(outValid === 1'b0, "R1", "idle outValid", int'(outValid), 0);
    // R1: tables still zero right after reset
    send(2, 5, 0, 0, "R1");
    for (int g = 0; g < 16; g++) begin
      wrTbl(1'b0, g, 8 + 2 * g, g % 4);
      wrTbl(1'b1, g, 48 + g, 0);
    end
    // R3 intra group in several modes
    send(3, 3, 0, 0, "R3");
    send(3, 3, 2, 0, "R3");
    send(5, 5, 3, 0, "R3");
    // R4 single direct
    send(1, 4, 0, 0, "R4");
    send(4, 1, 0, 0, "R4");
    // R5 multi direct, two destinations interleaved
    for (int n = 0; n < 5; n++) begin
      send(0, 3, 1, 0, "R5");
      send(0, 2, 1, 0, "R5");
    end
    // R6 round robin from reset pointer 0 (R1), skipping endpoints
    send(0, 1, 2, 0, "R1");
    send(4, 3, 2, 0, "R11");
    send(0, 2, 2, 3, "R7");
    send(1, 3, 2, 0, "R6");
    send(5, 4, 2, 2, "R7");
    send(2, 0, 2, 0, "R6");
    // R8 random, first draw from the seed
    send(1, 4, 3, 0, "R1");
    for (int n = 0; n < 6; n++) send(n % 6, (n + 2) % 6, 3, n % 2, "R8");
    // R9 fallback with two groups
    setCount(2);
    send(0, 1, 2, 0, "R9");
    send(1, 0, 3, 0, "R9");
    setCount(6);
    send(0, 5, 2, 0, "R9");
    send(2, 3, 3, 0, "R9");
    // full population, wrap of the scan
    setCount(16);
    for (int n = 0; n < 8; n++) send(15 - n, 14 - n, 2, 0, "R11");
    for (int n = 0; n < 8; n++) send(n, 15 - n, 3, 0, "R11");
    // R10 table rewrite used on the next packet
    wrTbl(1'b0, 5, 30, 1);
    send(0, 5, 0, 0, "R10");
    send(0, 5, 1, 0, "R10");
    send(0, 5, 1, 0, "R10");
    wrTbl(1'b1, 7, 2, 0);
    send(7, 7, 1, 0, "R10");
    repeat (3) @(posedge clk);
    chk(expQ.size() == 0, "R2", "pending results", expQ.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule